// File: doc/BRIEF.md
# Block-wise symmetric max-scaled quantizer

This block turns a stream of signed fixed-point samples into signed 8-bit codes, one block of `BLK_LEN` samples at a time. Each block gets its own scale: the largest magnitude found among its samples. Every sample of the block is then mapped to `round(x*127/s)`. The mapping is symmetric and has no offset, so zero always maps to code 0. Because of this, a single large sample only coarsens the resolution of its own block and leaves the rest of the tensor alone.

The whole block has to be seen before any sample can be scaled. For this reason incoming samples land in a two-bank buffer. While one bank is being scaled, the next block fills the other bank. A sequential divider forms a ceiling reciprocal `127/s` once per block, with enough fraction bits that the multiply-and-round gives the exactly rounded code. The output stream carries the code, a block-start flag and the block's scale.

A separate one-stage dequantize path rebuilds a sample value from a code and a scale. The input side has a valid/ready pair that stalls only while both buffer banks hold blocks that have not been scaled yet. The output side has no backpressure.

Top module: `blkq_quantizer`

## Requirements
- R1: The scale of a block equals the largest absolute value among its `BLK_LEN` samples. The scale is shown on `out_scale_o` with every code of that block, and `out_first_o` is 1 only with the block's first code.
- R2: For a nonzero scale s, each code equals x*127/s rounded to the nearest integer, with ties rounded away from zero (magnitude `floor((254*|x| + s) / (2*s))`, sign of x).
- R3: Codes always lie in -127..+127; the value -128 never appears, including for the most negative input.
- R4: A block whose samples are all zero reports scale 0 and gives code 0 for every sample.
- R5: Each block's scale depends only on that block. A block that follows one with an outlier is quantized with its own, smaller scale.
- R6: Codes come out in input order, and the `BLK_LEN` codes of a block appear on consecutive clock cycles.
- R7: Input is accepted while the next block is being scaled. `in_ready_o` drops only when both buffer banks hold unscaled blocks.
- R8: `deq_value_o` equals code*s/127 rounded to nearest with ties away from zero, one cycle after `deq_valid_i`, with `deq_valid_o` marking it.
- R9: For every sample, the round-trip error |q*s/127 - x| is at most s/254.
- R10: After reset, no code is emitted, `deq_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | DATA_W | Signed input sample |
| in_ready_o | output | 1 | Input sample accepted this cycle when high |
| out_valid_o | output | 1 | Code valid |
| out_first_o | output | 1 | First code of a block |
| out_code_o | output | 8 | Signed code |
| out_scale_o | output | DATA_W | Block scale (largest magnitude) |
| deq_valid_i | input | 1 | Dequantize request valid |
| deq_code_i | input | 8 | Signed code to dequantize |
| deq_scale_i | input | DATA_W | Scale for the dequantize request |
| deq_valid_o | output | 1 | Dequantized value valid |
| deq_value_o | output | DATA_W+1 | Signed reconstructed value |

## Verification
The assertions assume the following about the inputs:
- `in_data_i` is held stable while `in_valid_i` waits for ready.
- Dequantize requests carry codes in -127..+127. This is what makes the magnitude bound on `deq_value_o` hold.

The stimulus meets both assumptions:
- The input driver holds each sample until it is taken.
- The dequantize sweep walks only codes -127..+127, across every scale from 0 to 128.

// File: rtl/blkq_pkg.sv
package blkq_pkg;
  localparam int CODE_W   = 8;
  localparam int CODE_MAX = 127;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_DIV,
    SQ_EMIT
  } blkq_state_e;
endpackage

// File: rtl/blkq_pingpong.sv
module blkq_pingpong #(
  parameter int DATA_W  = 16,
  parameter int BLK_LEN = 8,
  parameter int IDX_W   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_valid_i,
  input  logic signed [DATA_W-1:0] wr_data_i,
  output logic                     wr_ready_o,
  output logic                     rd_avail_o,
  output logic        [DATA_W-1:0] rd_scale_o,
  input  logic        [IDX_W-1:0]  rd_idx_i,
  output logic signed [DATA_W-1:0] rd_data_o,
  input  logic                     rd_release_i
);
  localparam int NBANK = 2;

  logic [NBANK-1:0]        full_q;
  logic                    wr_sel_q, rd_sel_q;
  logic [IDX_W-1:0]        wr_idx_q;
  logic [DATA_W-1:0]       run_max_q;
  logic [DATA_W-1:0]       mag, new_max;
  logic                    wr_fire, wr_last;
  logic signed [DATA_W-1:0] bank_word [NBANK];
  logic        [DATA_W-1:0] bank_scale [NBANK];

  assign wr_ready_o = !full_q[wr_sel_q];
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign wr_last    = (wr_idx_q == IDX_W'(BLK_LEN - 1));
  // unsigned magnitude; most negative value maps to 2^(DATA_W-1)
  assign mag        = wr_data_i[DATA_W-1] ? (~wr_data_i + 1'b1) : wr_data_i;
  assign new_max    = (wr_idx_q == '0) ? mag : ((mag > run_max_q) ? mag : run_max_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_sel_q  <= 1'b0;
      wr_idx_q  <= '0;
      run_max_q <= '0;
    end else if (wr_fire) begin
      run_max_q <= new_max;
      if (wr_last) begin
        wr_idx_q <= '0;
        wr_sel_q <= !wr_sel_q;
      end else begin
        wr_idx_q <= wr_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_sel_q <= 1'b0;
    else if (rd_release_i) rd_sel_q <= !rd_sel_q;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic signed [DATA_W-1:0] mem [BLK_LEN];
    logic        [DATA_W-1:0] scale_q;
    logic                     sel_wr, sel_rd;

    assign sel_wr = (wr_sel_q == 1'(b));
    assign sel_rd = (rd_sel_q == 1'(b));

    always_ff @(posedge clk_i) begin
      if (wr_fire && sel_wr) mem[wr_idx_q] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q[b] <= 1'b0;
        scale_q   <= '0;
      end else if (wr_fire && wr_last && sel_wr) begin
        full_q[b] <= 1'b1;
        scale_q   <= new_max;
      end else if (rd_release_i && sel_rd) begin
        full_q[b] <= 1'b0;
      end
    end

    assign bank_word[b]  = mem[rd_idx_i];
    assign bank_scale[b] = scale_q;
  end

  assign rd_avail_o = full_q[rd_sel_q];
  assign rd_scale_o = bank_scale[rd_sel_q];
  assign rd_data_o  = bank_word[rd_sel_q];

  // R7: a bank is only handed back after it was offered as full
  p_release_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_release_i |-> rd_avail_o);
endmodule

// File: rtl/blkq_recip.sv
module blkq_recip #(
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 31,
  parameter int RECIP_W = 38
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DATA_W-1:0]  den_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [RECIP_W-1:0] recip_o
);
  localparam int CNT_W = $clog2(RECIP_W + 1);

  logic [RECIP_W-1:0] num_q, quo_q;
  logic [DATA_W-1:0]  rem_q, den_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, done_q;
  logic [DATA_W:0]    trial, diff;
  logic               ge;

  assign trial = {rem_q, num_q[RECIP_W-1]};
  assign ge    = (trial >= {1'b0, den_q});
  assign diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        // ceiling: (127 * 2^FRAC_W + s - 1) / s
        num_q  <= (RECIP_W'(127) << FRAC_W) + RECIP_W'(den_i) - RECIP_W'(1);
        den_q  <= den_i;
        rem_q  <= '0;
        quo_q  <= '0;
        cnt_q  <= CNT_W'(RECIP_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        num_q <= num_q << 1;
        quo_q <= {quo_q[RECIP_W-2:0], ge};
        rem_q <= ge ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign recip_o = quo_q;

  // R2: a finished reciprocal follows a busy iteration
  p_done_after_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  p_no_restart_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

// File: rtl/blkq_scale_elem.sv
module blkq_scale_elem #(
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 31,
  parameter int RECIP_W = 38
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic                     in_first_i,
  input  logic                     in_zero_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  input  logic        [RECIP_W-1:0] in_recip_i,
  input  logic        [DATA_W-1:0] in_scale_i,
  output logic                     out_valid_o,
  output logic                     out_first_o,
  output logic signed [7:0]        out_code_o,
  output logic        [DATA_W-1:0] out_scale_o
);
  import blkq_pkg::*;
  localparam int PROD_W = DATA_W + RECIP_W;

  logic [DATA_W-1:0] mag;
  logic [PROD_W-1:0] prod, rnd, q_full;
  logic [6:0]        sat;
  logic signed [7:0] code;

  assign mag    = in_data_i[DATA_W-1] ? (~in_data_i + 1'b1) : in_data_i;
  assign prod   = PROD_W'(mag) * PROD_W'(in_recip_i);
  assign rnd    = prod + (PROD_W'(1) << (FRAC_W - 1));
  assign q_full = rnd >> FRAC_W;
  assign sat    = (q_full > PROD_W'(CODE_MAX)) ? 7'(CODE_MAX) : q_full[6:0];

  always_comb begin
    if (in_zero_i)               code = '0;
    else if (in_data_i[DATA_W-1]) code = -$signed({1'b0, sat});
    else                         code = $signed({1'b0, sat});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_first_o <= 1'b0;
      out_code_o  <= '0;
      out_scale_o <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_first_o <= in_first_i;
        out_code_o  <= code;
        out_scale_o <= in_scale_i;
      end
    end
  end

  p_code_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_code_o != -8'sd128));
  p_zero_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_zero_i) |=> (out_code_o == 8'sd0));
endmodule

// File: rtl/blkq_dequant.sv
module blkq_dequant #(
  parameter int DATA_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic signed [7:0]      code_i,
  input  logic        [DATA_W-1:0] scale_i,
  output logic                   valid_o,
  output logic signed [DATA_W:0] value_o
);
  localparam int P_W = DATA_W + 8;

  logic [7:0]      cmag;
  logic [P_W-1:0]  prod;
  logic [P_W:0]    num, quot;
  logic [DATA_W:0] res, vmag;

  assign cmag = code_i[7] ? (~code_i + 1'b1) : code_i;
  assign prod = P_W'(cmag) * P_W'(scale_i);
  assign num  = {prod, 1'b0} + (P_W+1)'(127);
  assign quot = num / (P_W+1)'(254);
  assign res  = quot[DATA_W:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      value_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) value_o <= code_i[7] ? -$signed(res) : $signed(res);
    end
  end

  assign vmag = value_o[DATA_W] ? (~value_o + 1'b1) : value_o;

  // R8: with codes kept in -127..127, a rebuilt value never exceeds its scale
  p_deq_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i) && ($past(code_i) != -8'sd128))
      |-> (vmag <= {1'b0, $past(scale_i)}));
endmodule

// File: rtl/blkq_quantizer.sv
module blkq_quantizer #(
  parameter int DATA_W  = 16,
  parameter int BLK_LEN = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  output logic                     in_ready_o,
  output logic                     out_valid_o,
  output logic                     out_first_o,
  output logic signed [7:0]        out_code_o,
  output logic        [DATA_W-1:0] out_scale_o,
  input  logic                     deq_valid_i,
  input  logic signed [7:0]        deq_code_i,
  input  logic        [DATA_W-1:0] deq_scale_i,
  output logic                     deq_valid_o,
  output logic signed [DATA_W:0]   deq_value_o
);
  import blkq_pkg::*;
  localparam int FRAC_W  = 2 * DATA_W - 1;
  localparam int RECIP_W = CODE_W - 1 + FRAC_W;
  localparam int IDX_W   = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;

  blkq_state_e              state_q;
  logic [IDX_W-1:0]         idx_q;
  logic [DATA_W-1:0]        scale_q;
  logic                     zero_q;
  logic                     rd_avail, rd_release, div_start, div_busy, div_done;
  logic [DATA_W-1:0]        rd_scale;
  logic signed [DATA_W-1:0] rd_data;
  logic [RECIP_W-1:0]       recip;
  logic                     emit, emit_last;

  blkq_pingpong #(.DATA_W(DATA_W), .BLK_LEN(BLK_LEN), .IDX_W(IDX_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_valid_i  (in_valid_i),
    .wr_data_i   (in_data_i),
    .wr_ready_o  (in_ready_o),
    .rd_avail_o  (rd_avail),
    .rd_scale_o  (rd_scale),
    .rd_idx_i    (idx_q),
    .rd_data_o   (rd_data),
    .rd_release_i(rd_release)
  );

  blkq_recip #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .RECIP_W(RECIP_W)) u_recip (
    .clk_i, .rst_ni,
    .start_i(div_start),
    .den_i  (rd_scale),
    .busy_o (div_busy),
    .done_o (div_done),
    .recip_o(recip)
  );

  assign div_start  = (state_q == SQ_IDLE) && rd_avail && (rd_scale != '0);
  assign emit       = (state_q == SQ_EMIT);
  assign emit_last  = emit && (idx_q == IDX_W'(BLK_LEN - 1));
  assign rd_release = emit_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      scale_q <= '0;
      zero_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (rd_avail) begin
          scale_q <= rd_scale;
          zero_q  <= (rd_scale == '0);
          idx_q   <= '0;
          state_q <= (rd_scale == '0) ? SQ_EMIT : SQ_DIV;
        end
        SQ_DIV: if (div_done) state_q <= SQ_EMIT;
        SQ_EMIT: begin
          if (emit_last) begin
            idx_q   <= '0;
            state_q <= SQ_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  blkq_scale_elem #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .RECIP_W(RECIP_W)) u_scale (
    .clk_i, .rst_ni,
    .in_valid_i (emit),
    .in_first_i (idx_q == '0),
    .in_zero_i  (zero_q),
    .in_data_i  (rd_data),
    .in_recip_i (recip),
    .in_scale_i (scale_q),
    .out_valid_o,
    .out_first_o,
    .out_code_o,
    .out_scale_o
  );

  blkq_dequant #(.DATA_W(DATA_W)) u_deq (
    .clk_i, .rst_ni,
    .valid_i(deq_valid_i),
    .code_i (deq_code_i),
    .scale_i(deq_scale_i),
    .valid_o(deq_valid_o),
    .value_o(deq_value_o)
  );

  // R6: codes after the first of a block follow on back-to-back cycles
  p_contig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_first_o) |-> $past(out_valid_o));
  // R1: scale stays put across the codes of one block
  p_scale_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_first_o) |-> $stable(out_scale_o));
  p_div_only_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> !zero_q);
endmodule

// File: tb/blkq_quantizer_test.sv
module blkq_quantizer_test;
  localparam int DW  = 8;
  localparam int BL  = 4;
  localparam int NB  = 262;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic                 in_ready;
  logic                 out_valid, out_first;
  logic signed [7:0]    out_code;
  logic        [DW-1:0] out_scale;
  logic                 deq_valid = 1'b0;
  logic signed [7:0]    deq_code = '0;
  logic        [DW-1:0] deq_scale = '0;
  logic                 deq_valid_o;
  logic signed [DW:0]   deq_value;

  int n_vec = 0, n_bad = 0;
  int mb = 0, me = 0;
  bit prev_valid = 1'b0;
  int overlap_cyc = 0, stall_cyc = 0;

  always #10 clk = !clk;

  blkq_quantizer #(.DATA_W(DW), .BLK_LEN(BL)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_first_o(out_first),
    .out_code_o(out_code), .out_scale_o(out_scale),
    .deq_valid_i(deq_valid), .deq_code_i(deq_code), .deq_scale_i(deq_scale),
    .deq_valid_o(deq_valid_o), .deq_value_o(deq_value)
  );

  function automatic int elem(int b, int e);
    int v;
    if (b < 256) begin
      if (e == 0) return b - 128;
      v = ((b * 29 + e * 71 + 13) % 256) - 128;
      return v / (1 << (b % 6));
    end
    case (b)
      257: return (e == 3) ? -128 : (e == 0) ? 3 : (e == 1) ? -2 : 1;
      258: return (e == 0) ? 1 : 0;
      259: return (e == 3) ? -1 : 0;
      261: return (e == 1) ? 127 : -127;
      default: return 0;
    endcase
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int blk_scale(int b);
    int s = 0;
    for (int e = 0; e < BL; e++) if (iabs(elem(b, e)) > s) s = iabs(elem(b, e));
    return s;
  endfunction

  function automatic int exp_code(int x, int s);
    int m;
    if (s == 0) return 0;
    m = (254 * iabs(x) + s) / (2 * s);
    if (m > 127) m = 127;
    return (x < 0) ? -m : m;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (block %0d elem %0d)", req, act, expv, mb, me);
    end
  endtask

  task automatic push(int x);
    in_valid = 1'b1;
    in_data  = DW'(x);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // stream monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid && !in_ready) stall_cyc++;
      if (in_valid && in_ready && out_valid) overlap_cyc++;
      if (out_valid && mb < NB) begin
        int x, s, q, ec;
        x  = elem(mb, me);
        s  = blk_scale(mb);
        q  = int'(out_code);
        ec = exp_code(x, s);
        check(out_first == (me == 0), "R1 first flag", int'(out_first), int'(me == 0));
        check(int'(out_scale) == s, "R1 scale", int'(out_scale), s);
        if (s == 0) check(q == 0, "R4 zero block code", q, 0);
        else if (mb == 258 || mb == 259) check(q == ec, "R5 scale after outlier", q, ec);
        else check(q == ec, "R2 code", q, ec);
        check(q >= -127 && q <= 127, "R3 range", q, ec);
        check(iabs(2 * q * s - 254 * x) <= s, "R9 round trip", 2 * q * s, 254 * x);
        if (me != 0) check(prev_valid, "R6 consecutive codes", int'(prev_valid), 1);
        if (me == BL - 1) begin me = 0; mb++; end
        else me++;
      end
      prev_valid = out_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid reset", int'(out_valid), 0);
    check(deq_valid_o == 1'b0, "R10 deq_valid reset", int'(deq_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R10 in_ready reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R10 idle output", int'(out_valid), 0);

    for (int b = 0; b < NB; b++)
      for (int e = 0; e < BL; e++) push(elem(b, e));
    in_valid = 1'b0;
    while (mb < NB) @(negedge clk);
    repeat (4) @(negedge clk);
    check(!out_valid, "R6 no extra codes", int'(out_valid), 0);
    check(overlap_cyc > 0, "R7 input accepted while scaling", overlap_cyc, 1);
    check(stall_cyc > 0, "R7 stall when both banks full", stall_cyc, 1);

    // dequantize sweep, R8
    for (int s = 0; s <= 128; s++) begin
      for (int c = -127; c <= 127; c++) begin
        int m, ev;
        deq_valid = 1'b1;
        deq_code  = 8'(c);
        deq_scale = DW'(s);
        @(negedge clk);
        deq_valid = 1'b0;
        m  = (2 * iabs(c) * s + 127) / 254;
        ev = (c < 0) ? -m : m;
        check(deq_valid_o, "R8 deq valid", int'(deq_valid_o), 1);
        if (int'(deq_value) != ev)
          $display("  (R8 code %0d scale %0d)", c, s);
        check(int'(deq_value) == ev, "R8 dequant", int'(deq_value), ev);
      end
    end
    @(negedge clk);
    check(!deq_valid_o, "R8 deq valid drop", int'(deq_valid_o), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule